// File: doc/BRIEF.md
# Triple-Redundant Processor Health Monitor

This block checks a processor's status outputs for signs of malfunction. Three identical monitor replicas each receive their own copy of the status signals. Each replica runs the same three checks:

- **Reset-request consistency:** the timer-driven reset request must match the OR of the chip, core and system reset requests.
- **Cache write-through:** the write-through indicator must stay high.
- **Bus error:** a bus-error indication must not appear.

A replica reports an error only after voting: at least two of the three replicas must agree. This masks a single corrupted replica or a single faulty input copy.

Each replica registers its inputs before it checks them. The consistency check runs a small state machine per replica with three states:

- `WD_CLEAN`: no mismatch is seen.
- `WD_SUSPECT`: a mismatch is present and is being counted.
- `WD_FAULT`: the mismatch has lasted `PERSIST` registered cycles.

The transitions are:

- **clean→suspect:** a mismatch appears while `PERSIST` > 1.
- **clean→fault:** a mismatch appears while `PERSIST` = 1.
- **suspect→fault:** the count reaches `PERSIST`.
- **suspect→clean:** the mismatch goes away before the count is reached.
- **fault→clean:** the mismatch goes away.

A mismatch that clears before the count is reached is treated as skew and raises nothing.

The voted flags are sticky until the clear input is pulsed. The parameter `MODE` selects how the combined flag is formed:

- `VOTE_PER_SIGNAL`: each check is voted first, and the combined flag is the OR of the voted flags.
- `VOTE_PER_MONITOR`: each replica first ORs its own three errors, and that per-replica result is then voted.

A disagreement output is high in every cycle in which the replicas' raw results are not unanimous.

Top module: `hm_tmr_monitor`

## Requirements
- R1: After reset, all flag outputs and `disagree_o` are 0.
- R2: Replica i reports a consistency mismatch when `tmr_rst_req_i[i]` differs from the OR of `chip_rst_req_i[i]`, `core_rst_req_i[i]` and `sys_rst_req_i[i]`. A matched set raises no error.
- R3: Replica i reports a write-through error while `wr_thru_i[i]` is 0.
- R4: Replica i reports a bus error while `bus_err_i[i]` is 1. A voted raw error is registered into its flag one clock after the input is registered, so the flag is visible after the second clock edge.
- R5: A flag is raised only when at least two replicas report that error. A single reporting replica is masked.
- R6: Flags stay set after the cause goes away. A cycle with `clr_i` high makes every flag 0 on the following cycle, and clear takes priority over new errors.
- R7: `disagree_o` is 1, one cycle after the raw results, whenever the three replicas' raw results are not all equal, even when the vote resolves.
- R8: A consistency mismatch present for fewer than `PERSIST` consecutive registered cycles raises nothing. A mismatch present for exactly `PERSIST` cycles in a voting majority sets `wd_err_o`.
- R9: With `MODE`=`VOTE_PER_SIGNAL`, `any_err_o` is the OR of the three flags. With `VOTE_PER_MONITOR`, `any_err_o` is the sticky vote of the replicas' own OR of their errors, so three different single errors set it.
- R10: Any set individual flag implies `any_err_o` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Clears all sticky flags |
| chip_rst_req_i | input | 3 | Chip reset request, one copy per replica |
| core_rst_req_i | input | 3 | Core reset request, one copy per replica |
| sys_rst_req_i | input | 3 | System reset request, one copy per replica |
| tmr_rst_req_i | input | 3 | Timer reset request, one copy per replica |
| wr_thru_i | input | 3 | Write-through indicator (1 = healthy), per replica |
| bus_err_i | input | 3 | Bus error indication, per replica |
| wd_err_o | output | 1 | Voted sticky reset-consistency error |
| wt_err_o | output | 1 | Voted sticky write-through error |
| bus_err_o | output | 1 | Voted sticky bus error |
| any_err_o | output | 1 | Combined error, formed per `MODE` |
| disagree_o | output | 1 | Replicas' raw results differ |

## Verification
The assertions assume that the replica inputs are synchronous to `clk` and hold their values across each edge. They also assume that reset is held for at least one edge before checking begins, so the two-cycle input-to-flag relations are only checked once two edges have passed since reset. The stimulus drives every input on the falling edge and holds each pattern for a whole number of cycles. It creates faults only by making the three replica copies differ at the ports.

// File: rtl/hm_pkg.sv
package hm_pkg;
    localparam int NMON = 3;

    typedef struct packed {
        logic wd;
        logic wt;
        logic bus;
    } hm_err_t;

    typedef enum logic [1:0] {
        WD_CLEAN   = 2'd0,
        WD_SUSPECT = 2'd1,
        WD_FAULT   = 2'd2
    } wd_state_e;

    typedef enum logic {
        VOTE_PER_SIGNAL  = 1'b0,
        VOTE_PER_MONITOR = 1'b1
    } vote_mode_e;
endpackage

// File: rtl/hm_voter.sv
module hm_voter #(
    parameter int W = 3
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] maj_o,
    output logic         split_o
);
    always_comb begin
        maj_o   = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
        split_o = |((a_i ^ b_i) | (b_i ^ c_i));
    end
endmodule

// File: rtl/hm_checker.sv
module hm_checker
    import hm_pkg::*;
#(
    parameter int PERSIST = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    chip_i,
    input  logic    core_i,
    input  logic    sys_i,
    input  logic    tmr_i,
    input  logic    wthru_i,
    input  logic    bus_i,
    output hm_err_t err_o
);
    localparam int CW = (PERSIST < 2) ? 1 : $clog2(PERSIST + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PERSIST);

    logic chip_q, core_q, sys_q, tmr_q, wthru_q, bus_q;
    logic mismatch;
    wd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Input capture stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_q  <= 1'b0;
            core_q  <= 1'b0;
            sys_q   <= 1'b0;
            tmr_q   <= 1'b0;
            wthru_q <= 1'b1;
            bus_q   <= 1'b0;
        end else begin
            chip_q  <= chip_i;
            core_q  <= core_i;
            sys_q   <= sys_i;
            tmr_q   <= tmr_i;
            wthru_q <= wthru_i;
            bus_q   <= bus_i;
        end
    end

    assign mismatch = tmr_q != (chip_q | core_q | sys_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_CLEAN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_CLEAN: begin
                if (mismatch) begin
                    cnt_d   = CW'(1);
                    state_d = (PERSIST <= 1) ? WD_FAULT : WD_SUSPECT;
                end
            end
            WD_SUSPECT: begin
                if (!mismatch) begin
                    state_d = WD_CLEAN;
                    cnt_d   = '0;
                end else if (cnt_q + CW'(1) >= LIMIT) begin
                    state_d = WD_FAULT;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            WD_FAULT: begin
                if (!mismatch) begin
                    state_d = WD_CLEAN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = WD_CLEAN;
                cnt_d   = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        err_o.wd  = (state_q == WD_FAULT);
        err_o.wt  = !wthru_q;
        err_o.bus = bus_q;
    end
endmodule

// File: rtl/hm_tmr_monitor.sv
module hm_tmr_monitor
    import hm_pkg::*;
#(
    parameter int         PERSIST = 4,
    parameter vote_mode_e MODE    = VOTE_PER_SIGNAL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic [2:0] chip_rst_req_i,
    input  logic [2:0] core_rst_req_i,
    input  logic [2:0] sys_rst_req_i,
    input  logic [2:0] tmr_rst_req_i,
    input  logic [2:0] wr_thru_i,
    input  logic [2:0] bus_err_i,
    output logic       wd_err_o,
    output logic       wt_err_o,
    output logic       bus_err_o,
    output logic       any_err_o,
    output logic       disagree_o
);
    hm_err_t raw [NMON];
    hm_err_t sig_vote;
    hm_err_t flags_q;
    logic    sig_split;
    logic    comb_split;
    logic    dis_q;

    for (genvar g = 0; g < NMON; g++) begin : g_mon
        hm_checker #(.PERSIST(PERSIST)) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .chip_i  (chip_rst_req_i[g]),
            .core_i  (core_rst_req_i[g]),
            .sys_i   (sys_rst_req_i[g]),
            .tmr_i   (tmr_rst_req_i[g]),
            .wthru_i (wr_thru_i[g]),
            .bus_i   (bus_err_i[g]),
            .err_o   (raw[g])
        );
    end

    hm_voter #(.W(3)) u_sig_vote (
        .a_i     (raw[0]),
        .b_i     (raw[1]),
        .c_i     (raw[2]),
        .maj_o   (sig_vote),
        .split_o (sig_split)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | sig_vote;
        end
    end

    if (MODE == VOTE_PER_MONITOR) begin : g_per_mon
        logic comb_vote;
        logic comb_q;
        hm_voter #(.W(1)) u_comb_vote (
            .a_i     (|raw[0]),
            .b_i     (|raw[1]),
            .c_i     (|raw[2]),
            .maj_o   (comb_vote),
            .split_o (comb_split)
        );
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                comb_q <= 1'b0;
            end else begin
                comb_q <= comb_q | comb_vote;
            end
        end
        assign any_err_o = comb_q;
    end else begin : g_per_sig
        assign comb_split = 1'b0;
        assign any_err_o  = |flags_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
        end else begin
            dis_q <= sig_split | comb_split;
        end
    end

    assign wd_err_o   = flags_q.wd;
    assign wt_err_o   = flags_q.wt;
    assign bus_err_o  = flags_q.bus;
    assign disagree_o = dis_q;
endmodule

module hm_tmr_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_i,
    input logic [2:0] wr_thru_i,
    input logic [2:0] bus_err_i,
    input logic       wd_err_o,
    input logic       wt_err_o,
    input logic       bus_err_o,
    input logic       any_err_o
);
    logic [1:0] since_q;
    logic       bus_maj, wt_low_maj;

    always_ff @(posedge clk) begin
        if (!rst_n) since_q <= '0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    assign bus_maj    = (bus_err_i[0] & bus_err_i[1]) | (bus_err_i[1] & bus_err_i[2]) | (bus_err_i[0] & bus_err_i[2]);
    assign wt_low_maj = (!wr_thru_i[0] & !wr_thru_i[1]) | (!wr_thru_i[1] & !wr_thru_i[2]) | (!wr_thru_i[0] & !wr_thru_i[2]);

    // R4
    bus_flag_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd2 && $past(bus_maj, 2) && !$past(clr_i)) |-> bus_err_o);

    // R3
    wt_flag_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd2 && $past(wt_low_maj, 2) && !$past(clr_i)) |-> wt_err_o);

    // R6
    wd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_err_o && !clr_i) |=> wd_err_o);

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !(wd_err_o || wt_err_o || bus_err_o || any_err_o));

    // R10
    any_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_err_o || wt_err_o || bus_err_o) |-> any_err_o);
endmodule

bind hm_tmr_monitor hm_tmr_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .wr_thru_i (wr_thru_i),
    .bus_err_i (bus_err_i),
    .wd_err_o  (wd_err_o),
    .wt_err_o  (wt_err_o),
    .bus_err_o (bus_err_o),
    .any_err_o (any_err_o)
);

// File: tb/hm_tmr_monitor_test.sv
`timescale 1ns/1ps
module hm_tmr_monitor_test;
    import hm_pkg::*;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [2:0] chip = '0, core = '0, sys = '0, tmr = '0, wt = 3'b111, bus = '0;
    logic wd_o, wt_o, bus_o, any_o, dis_o;
    logic wd_m, wt_m, bus_m, any_m, dis_m;

    always #5 clk = ~clk;

    hm_tmr_monitor #(.PERSIST(P), .MODE(VOTE_PER_SIGNAL)) uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .chip_rst_req_i(chip), .core_rst_req_i(core), .sys_rst_req_i(sys),
        .tmr_rst_req_i(tmr), .wr_thru_i(wt), .bus_err_i(bus),
        .wd_err_o(wd_o), .wt_err_o(wt_o), .bus_err_o(bus_o),
        .any_err_o(any_o), .disagree_o(dis_o));

    hm_tmr_monitor #(.PERSIST(P), .MODE(VOTE_PER_MONITOR)) uut_pm (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .chip_rst_req_i(chip), .core_rst_req_i(core), .sys_rst_req_i(sys),
        .tmr_rst_req_i(tmr), .wr_thru_i(wt), .bus_err_i(bus),
        .wd_err_o(wd_m), .wt_err_o(wt_m), .bus_err_o(bus_m),
        .any_err_o(any_m), .disagree_o(dis_m));

    typedef struct {
        string      tag;
        logic [4:0] exp;     // wd, wt, bus, any, dis (per-signal instance)
        logic       exp_pm;  // any_err_o of per-monitor instance
    } item_t;

    item_t q[$];
    event  pushed;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Monitor: pops expectations and compares against outputs
    initial begin
        forever begin
            @(pushed);
            while (q.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it  = q.pop_front();
                act = {wd_o, wt_o, bus_o, any_o, dis_o};
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got wd/wt/bus/any/dis=%b expected %b", it.tag, act, it.exp);
                end
                n_chk++;
                if (any_m !== it.exp_pm) begin
                    n_bad++;
                    $display("FAIL %s: per-monitor any got %b expected %b", it.tag, any_m, it.exp_pm);
                end
            end
        end
    end

    task automatic set_in(input logic [2:0] c, co, s, t, w, b);
        chip = c; core = co; sys = s; tmr = t; wt = w; bus = b;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [4:0] e, input logic epm);
        item_t it;
        it.tag = tag; it.exp = e; it.exp_pm = epm;
        q.push_back(it);
        -> pushed;
        #1;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        wait_cyc(1);
        clr = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        expect_out("R1 reset state", 5'b00000, 1'b0);
        rst_n = 1'b1;
        wait_cyc(2);
        expect_out("R1 after release", 5'b00000, 1'b0);

        // R2: consistent requests, all replicas
        set_in(3'b111, 3'b000, 3'b000, 3'b111, 3'b111, 3'b000);
        wait_cyc(P + 4);
        expect_out("R2 chip req matched", 5'b00000, 1'b0);
        set_in(3'b000, 3'b111, 3'b111, 3'b111, 3'b111, 3'b000);
        wait_cyc(P + 4);
        expect_out("R2 core+sys req matched", 5'b00000, 1'b0);

        // R5/R7: single write-through low is masked but flagged as disagreement
        set_in('0, '0, '0, '0, 3'b110, '0);
        wait_cyc(P + 4);
        expect_out("R5 R7 single wt low masked", 5'b00001, 1'b0);

        // R4/R5: two replicas see bus error
        set_in('0, '0, '0, '0, 3'b111, 3'b011);
        wait_cyc(2);
        expect_out("R4 bus flag after two edges", 5'b00111, 1'b1);

        // R6: sticky after cause removed
        set_in('0, '0, '0, '0, 3'b111, 3'b000);
        wait_cyc(P + 4);
        expect_out("R6 bus sticky", 5'b00110, 1'b1);
        pulse_clr();
        expect_out("R6 clear", 5'b00000, 1'b0);

        // R3: write-through low everywhere
        set_in('0, '0, '0, '0, 3'b000, '0);
        wait_cyc(P + 4);
        expect_out("R3 wt low all", 5'b01010, 1'b1);

        // R6: clear while cause persists, then re-raised
        pulse_clr();
        expect_out("R6 clear wins", 5'b00000, 1'b0);
        wait_cyc(2);
        expect_out("R6 re-raised", 5'b01010, 1'b1);
        set_in('0, '0, '0, '0, 3'b111, '0);
        wait_cyc(3);
        pulse_clr();
        wait_cyc(1);
        expect_out("R6 cleared again", 5'b00000, 1'b0);

        // R8: short mismatch is tolerated
        set_in('0, '0, '0, 3'b111, 3'b111, '0);
        wait_cyc(P - 1);
        set_in('0, '0, '0, '0, 3'b111, '0);
        wait_cyc(P + 4);
        expect_out("R8 short mismatch ignored", 5'b00000, 1'b0);

        // R8/R2: mismatch for exactly PERSIST cycles
        set_in('0, '0, '0, 3'b111, 3'b111, '0);
        wait_cyc(P);
        set_in('0, '0, '0, '0, 3'b111, '0);
        wait_cyc(P + 4);
        expect_out("R8 R2 mismatch at limit", 5'b10010, 1'b1);
        pulse_clr();

        // R2: timer request missing with core request asserted
        set_in(3'b000, 3'b111, 3'b000, 3'b000, 3'b111, '0);
        wait_cyc(P + 4);
        expect_out("R2 missing timer req", 5'b10010, 1'b1);
        set_in('0, '0, '0, '0, 3'b111, '0);
        wait_cyc(3);
        pulse_clr();
        wait_cyc(1);

        // R9: each replica sees a different single error
        set_in('0, '0, '0, 3'b001, 3'b101, 3'b100);
        wait_cyc(P + 4);
        expect_out("R9 R7 mode split", 5'b00001, 1'b1);
        set_in('0, '0, '0, '0, 3'b111, '0);
        wait_cyc(P + 4);
        expect_out("R9 after split", 5'b00000, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        wait_cyc(1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule